// File: doc/BRIEF.md
# Flash Program/Erase Control and Status Register

This block is a single byte-wide control and status register placed between a processor bus and a flash write/erase engine. Software uses it to arm programming, to enable a completion interrupt, and to poll or acknowledge the end of an operation. The block also turns a raw write/erase request, which an upstream command-sequence decoder produces, into a gated strobe toward the flash engine.

The register holds five kinds of field:

- an interrupt enable;
- a sticky completion flag;
- a write enable;
- a live ready indication taken from the engine's busy level;
- four spare bits that software can read and write freely.

The completion flag is set by the engine's done pulse and cleared by the start of an operation. Software can clear it by writing 0, while writing 1 leaves it alone. Once an operation has been started, further requests are refused until the engine reports completion. During a read-modify-write access the flag position always reads as 1, so such an access cannot clear the flag by accident.

The asynchronous reset input is released toward the register through a two-stage synchronizer.

Top module: `pe_ctrl_reg`

## Requirements
- R1: Bit positions are: interrupt enable at bit 7, completion flag at bit 6, write enable at bit 5, ready at bit 4, spare bits at bits 3..0. After reset, `bus_rdata` reads 0x10 when `eng_busy`=0 and 0x00 when `eng_busy`=1.
- R2: `irq` is 1 exactly when the stored interrupt enable and the completion flag are both 1. It is 0 whenever the enable is 0.
- R3: A cycle with `eng_done`=1 sets the completion flag at that clock edge and releases the request lock.
- R4: A bus write with bit 6 equal to 0 clears the completion flag. A bus write with bit 6 equal to 1 leaves the flag unchanged.
- R5: While `bus_rmw`=1, `bus_rdata` bit 6 reads 1 regardless of the flag. With `bus_rmw`=0 it shows the stored flag.
- R6: `pe_strobe` equals `req_raw` in the same cycle when the write enable is 1 and no operation is pending. It is never 1 while the write enable is 0.
- R7: A strobe clears the completion flag and marks an operation pending. While an operation is pending, requests produce no strobe, until a done pulse.
- R8: Bit 4 is read-only and always shows the inverse of `eng_busy`. The value written to bit 4 is ignored.
- R9: Bits 7, 5 and 3..0 take the written value at the edge that ends the write cycle.
- R10: When a done pulse and a software clear of the flag occur in the same cycle, the flag ends up 1.
- R11: Asserting `rst_n` low clears the register at once. After `rst_n` rises, the register ignores writes until the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write in this cycle |
| bus_rmw | input | 1 | Current access is a read-modify-write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from register state |
| eng_done | input | 1 | One-cycle pulse: write/erase algorithm finished |
| eng_busy | input | 1 | Level: flash engine busy |
| req_raw | input | 1 | Write/erase request from the command decoder |
| pe_strobe | output | 1 | Gated write/erase strobe to the flash engine |
| irq | output | 1 | Completion interrupt request |

## Verification
`pe_strobe` is a combinational function of `req_raw` and the stored state, so it is due in the same cycle as the request. The read data and `irq` depend on state that is updated only at the next rising edge. The exceptions are the ready bit and the read-modify-write override, which follow their inputs in the same cycle. The bench drives every input at a falling edge and samples 1 ns later. Each expected value therefore reflects the state left by the previous rising edge together with the inputs of the current cycle. The reset-release test counts rising edges after `rst_n` rises to confirm that the first write to take effect is the one in the third edge's cycle.

// File: rtl/pe_ctrl_pkg.sv
package pe_ctrl_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned SPARE_W  = 4;
  localparam int unsigned IEN_BIT  = 7;
  localparam int unsigned FLAG_BIT = 6;
  localparam int unsigned WEN_BIT  = 5;
  localparam int unsigned RDY_BIT  = 4;

  typedef struct packed {
    logic ien;
    logic flag;
    logic wen;
    logic lock;
  } ctl_state_t;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pe_ctrl_bits.sv
module pe_ctrl_bits
  import pe_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 hw_done,
  input  logic                 start,
  output ctl_state_t           st,
  output logic [SPARE_W-1:0]   spare
);
  ctl_state_t st_d;
  logic       st_upd;

  // next state: software write, then start, then done (done has final say)
  always_comb begin
    st_d = st;
    if (wr_en) begin
      st_d.ien = wdata[IEN_BIT];
      st_d.wen = wdata[WEN_BIT];
      if (!wdata[FLAG_BIT]) st_d.flag = 1'b0;
    end
    if (start) begin
      st_d.flag = 1'b0;
      st_d.lock = 1'b1;
    end
    if (hw_done) begin
      st_d.flag = 1'b1;
      st_d.lock = 1'b0;
    end
  end

  assign st_upd = wr_en | start | hw_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st <= '0;
    else if (st_upd) st <= st_d;
  end

  // spare bits: one enabled flop each
  for (genvar g = 0; g < SPARE_W; g++) begin : g_spare
    logic bit_d;
    always_comb bit_d = wdata[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     spare[g] <= 1'b0;
      else if (wr_en) spare[g] <= bit_d;
    end
  end

  a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hw_done |=> (st.flag && !st.lock));
  a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_done && wr_en && !wdata[FLAG_BIT]) |=> st.flag);
  a_r4_one_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[FLAG_BIT] && !hw_done && !start) |=> (st.flag == $past(st.flag)));
  a_r7_start_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !hw_done) |=> (st.lock && !st.flag));
endmodule

// File: rtl/pe_ctrl_out.sv
module pe_ctrl_out
  import pe_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctl_state_t           st,
  input  logic [SPARE_W-1:0]   spare,
  input  logic                 busy,
  input  logic                 rmw,
  input  logic                 req_raw,
  output logic [REG_W-1:0]     rdata,
  output logic                 irq,
  output logic                 strobe
);
  always_comb begin
    rdata           = '0;
    rdata[IEN_BIT]  = st.ien;
    rdata[FLAG_BIT] = st.flag | rmw;
    rdata[WEN_BIT]  = st.wen;
    rdata[RDY_BIT]  = ~busy;
    rdata[SPARE_W-1:0] = spare;
  end

  assign irq    = st.ien & st.flag;
  assign strobe = req_raw & st.wen & ~st.lock;

  a_r6_no_strobe_without_wen: assert property (@(posedge clk) disable iff (!rst_n)
    !st.wen |-> !strobe);
  a_r7_lock_blocks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    st.lock |-> !strobe);
  a_r5_rmw_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    rmw |-> rdata[FLAG_BIT]);
  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !st.ien |-> !irq);
endmodule

// File: rtl/pe_ctrl_reg.sv
module pe_ctrl_reg
  import pe_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rmw,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             eng_done,
  input  logic             eng_busy,
  input  logic             req_raw,
  output logic             pe_strobe,
  output logic             irq
);
  logic               rst_n_sync;
  ctl_state_t         st;
  logic [SPARE_W-1:0] spare;

  pe_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  pe_ctrl_bits u_bits (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_en   (bus_wr),
    .wdata   (bus_wdata),
    .hw_done (eng_done),
    .start   (pe_strobe),
    .st      (st),
    .spare   (spare)
  );

  pe_ctrl_out u_out (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .st      (st),
    .spare   (spare),
    .busy    (eng_busy),
    .rmw     (bus_rmw),
    .req_raw (req_raw),
    .rdata   (bus_rdata),
    .irq     (irq),
    .strobe  (pe_strobe)
  );

  a_r8_ready_ignores_write: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (bus_wr && bus_wdata[RDY_BIT] && eng_busy) |-> !bus_rdata[RDY_BIT]);
  a_r2_irq_only_with_flag: assert property (@(posedge clk) disable iff (!rst_n_sync)
    irq |-> (bus_rdata[IEN_BIT] && (bus_rmw || bus_rdata[FLAG_BIT])));
endmodule

// File: tb/sim_pe_ctrl_reg.sv
module sim_pe_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  // {wr, rmw, wdata[7:0], done, busy, req, exp_rdata[7:0], exp_irq, exp_strobe}
  localparam logic [22:0] VEC [0:NVEC-1] = '{
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h10,1'b0,1'b0}, // 0 idle
    {1'b1,1'b0,8'hAF,1'b0,1'b1,1'b0, 8'h00,1'b0,1'b0}, // 1 write, busy
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'hBF,1'b0,1'b1}, // 2 request passes
    {1'b0,1'b0,8'h00,1'b0,1'b1,1'b1, 8'hAF,1'b0,1'b0}, // 3 locked
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 8'hBF,1'b0,1'b0}, // 4 done
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'hFF,1'b1,1'b0}, // 5 flag + irq
    {1'b0,1'b1,8'h00,1'b0,1'b0,1'b0, 8'hFF,1'b1,1'b0}, // 6 rmw
    {1'b1,1'b0,8'h40,1'b0,1'b0,1'b0, 8'hFF,1'b1,1'b0}, // 7 write 1 to flag
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h50,1'b0,1'b0}, // 8 flag kept, ien off
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'h50,1'b0,1'b0}, // 9 wen=0 blocks
    {1'b1,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h50,1'b0,1'b0}, // 10 clear flag
    {1'b0,1'b1,8'h00,1'b0,1'b0,1'b0, 8'h50,1'b0,1'b0}, // 11 rmw forces 1
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'h10,1'b0,1'b0}, // 12 flag clear
    {1'b1,1'b0,8'hA5,1'b0,1'b0,1'b0, 8'h10,1'b0,1'b0}, // 13 write
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'hB5,1'b0,1'b1}, // 14 start
    {1'b1,1'b0,8'hA5,1'b1,1'b0,1'b0, 8'hB5,1'b0,1'b0}, // 15 done + clear
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'hF5,1'b1,1'b0}, // 16 set won
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b1, 8'hF5,1'b1,1'b1}, // 17 restart
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'hB5,1'b0,1'b0}, // 18 flag cleared by start
    {1'b0,1'b0,8'h00,1'b1,1'b0,1'b0, 8'hB5,1'b0,1'b0}, // 19 done
    {1'b0,1'b0,8'h00,1'b0,1'b0,1'b0, 8'hF5,1'b1,1'b0}  // 20 idle
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rmw, eng_done, eng_busy, req_raw;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pe_strobe, irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_ctrl_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rmw(bus_rmw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_done(eng_done),
    .eng_busy(eng_busy), .req_raw(req_raw), .pe_strobe(pe_strobe), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    bus_wr = 0; bus_rmw = 0; bus_wdata = 8'h00;
    eng_done = 0; eng_busy = 0; req_raw = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset value, ready", bus_rdata, 8'h10);
    check("R2 reset irq", {7'b0, irq}, 8'h00);
    eng_busy = 1; #1;
    check("R1 reset value, busy", bus_rdata, 8'h00);
    check("R8 ready follows busy", {7'b0, bus_rdata[4]}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {bus_wr, bus_rmw, bus_wdata, eng_done, eng_busy, req_raw} = VEC[i][22:10];
      #1;
      check($sformatf("R1/R4/R5/R8/R9/R10 rdata vec %0d", i), bus_rdata, VEC[i][9:2]);
      check($sformatf("R2/R3 irq vec %0d", i), {7'b0, irq}, {7'b0, VEC[i][1]});
      check($sformatf("R6/R7 strobe vec %0d", i), {7'b0, pe_strobe}, {7'b0, VEC[i][0]});
    end

    // R11: asynchronous clear, then two ignored edges after release
    @(negedge clk);
    idle_inputs();
    #2;
    rst_n = 0;
    #1;
    check("R11 async clear", bus_rdata, 8'h10);
    check("R11 async clear irq", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    bus_wr = 1; bus_wdata = 8'h0F;
    @(negedge clk);
    #1;
    check("R11 first edge ignored", bus_rdata, 8'h10);
    @(negedge clk);
    #1;
    check("R11 second edge ignored", bus_rdata, 8'h10);
    @(negedge clk);
    #1;
    check("R11 third edge takes write", bus_rdata, 8'h1F);
    check("R9 spare bits written", {4'h0, bus_rdata[3:0]}, 8'h0F);

    // R8: writing 1 to bit 4 while busy leaves ready low
    bus_wdata = 8'h10; eng_busy = 1;
    @(negedge clk);
    bus_wr = 0;
    #1;
    check("R8 bit 4 write ignored", bus_rdata, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule